// File: doc/BRIEF.md
# Voice Recorder Serial Command Shifter

This block is an SPI master. It sends one 16-bit instruction frame at a time to a serial voice record/playback device. A host sequencer gives a 10-bit address and a 6-bit control code with a one-cycle start strobe. The block then lowers the slave select line and runs sixteen clock pulses, most significant bit first. While it does so, it shifts the device's interrupt/status bits in from MISO. The device acts on the instruction when slave select rises. At that point the block gives a one-cycle done pulse together with the 16 captured status bits.

The serial clock idles low. Outgoing data changes only while the clock is low, so the device latches stable data on each rising edge. The device changes its output on falling edges, so the block samples MISO on rising edges. After each frame the block keeps slave select high for a minimum gap and reports busy. Opcode meaning and power-up timing belong to the sequencer that drives this block.

Top module: `vr_cmd_shifter`

## Requirements
- R1: During reset and right after it, `ss_n_o` is 1 and `sclk_o`, `mosi_o`, `busy_o`, `done_o` and `status_o` are 0.
- R2: A `start_i` sampled high while `busy_o` is low drives `ss_n_o` low and `busy_o` high on the next cycle. `busy_o` stays high until the inter-frame gap has ended.
- R3: The frame word is `{ctrl_i, addr_i}`: bit 15 is `ctrl_i[5]`, bits 15:10 hold the control code and bits 9:0 hold the address. The word is sent on `mosi_o` from bit 15 down to bit 0.
- R4: `mosi_o` changes only while `sclk_o` is low. Each bit is valid for HALF_DIV clocks before the rising edge that latches it. Outside the 16 bit slots `mosi_o` is 0.
- R5: `sclk_o` is low whenever `ss_n_o` is high. Each frame has exactly 16 rising edges, and every high and low half lasts HALF_DIV clocks. Slave select is low for one low half before the first rising edge and for one low half after the last falling edge, 33·HALF_DIV clocks in all, with no glitch.
- R6: `miso_i` is sampled once per rising SCLK edge. The first sample lands in status bit 15 and the last in bit 0.
- R7: `done_o` is a one-cycle pulse in the first cycle in which `ss_n_o` is high again. `status_o` carries the captured word in that cycle and holds it until the next done.
- R8: After a frame, `ss_n_o` stays high for at least GAP_CYC cycles, and `busy_o` stays high for exactly GAP_CYC cycles after `done_o` rises.
- R9: `start_i` while `busy_o` is high is ignored: the frame in flight and its word are unchanged, and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for one frame |
| addr_i | input | 10 | Address field of the instruction |
| ctrl_i | input | 6 | Control field of the instruction |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| done_o | output | 1 | One-cycle pulse when the frame has ended |
| status_o | output | 16 | Status bits captured from MISO |
| ss_n_o | output | 1 | Slave select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
The assertions assume that `miso_i` changes only on falling SCLK edges or when slave select falls, as a compliant device would. They make no assumption about when the host raises `start_i`. The bench's slave model follows the same rule, shifting its pattern out only on those events. Starts are issued both at idle and in the middle of frames and gaps, and some starts are held high continuously, so the ignore rule and the minimum gap are exercised at their edges.

// File: rtl/vr_cmd_shifter.sv
module vr_cmd_shifter #(
  parameter int HALF_DIV = 4,
  parameter int GAP_CYC  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [9:0]  addr_i,
  input  logic [5:0]  ctrl_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] status_o,
  output logic        ss_n_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [5:0] LAST_PH = 6'd32;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  st_t         st;
  logic [5:0]  ph;
  logic [DW-1:0] div;
  logic [GW-1:0] gcnt;
  logic [15:0] tx, rx;

  assign busy_o = (st != S_IDLE);
  assign sclk_o = (st == S_SHIFT) & ph[0];
  assign mosi_o = tx[15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; div <= '0; gcnt <= '0;
      tx <= '0; rx <= '0; status_o <= '0;
      ss_n_o <= 1'b1; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st <= S_SHIFT; ph <= '0; div <= '0;
          tx <= {ctrl_i, addr_i};
          ss_n_o <= 1'b0;
        end
        S_SHIFT: if (div == DW'(HALF_DIV - 1)) begin
          div <= '0;
          if (ph == LAST_PH) begin
            st <= S_GAP; gcnt <= '0;
            ss_n_o <= 1'b1; done_o <= 1'b1; status_o <= rx;
          end else begin
            ph <= ph + 6'd1;
            if (!ph[0]) rx <= {rx[14:0], miso_i};
            else        tx <= {tx[14:0], 1'b0};
          end
        end else begin
          div <= div + DW'(1);
        end
        S_GAP: if (gcnt == GW'(GAP_CYC - 1)) st <= S_IDLE;
               else gcnt <= gcnt + GW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [GW:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= (GW+1)'(GAP_CYC);
    else if (!ss_n_o) hi_cnt <= '0;
    else if (hi_cnt < (GW+1)'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
  end

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_o |-> !sclk_o);
  p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  p_busy_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n_o |-> busy_o);
  p_done_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ss_n_o && !$past(ss_n_o)));
  p_ss_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n_o && $past(ss_n_o)) |-> ($past(hi_cnt) >= (GW+1)'(GAP_CYC)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/vr_cmd_shifter_bench.sv
module vr_cmd_shifter_bench;
  localparam int H = 2;
  localparam int G = 3;
  localparam int FR = 33 * H;

  logic clk = 0, rst_n = 0, start = 0, miso = 0;
  logic [9:0] addr = '0;
  logic [5:0] ctrl = '0;
  logic busy, done, ss_n, sclk, mosi;
  logic [15:0] status;

  int checks = 0, errors = 0;

  vr_cmd_shifter #(.HALF_DIV(H), .GAP_CYC(G)) u_vr_cmd_shifter (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .ctrl_i(ctrl),
    .busy_o(busy), .done_o(done), .status_o(status),
    .ss_n_o(ss_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: cycles since accepted start, -1 when idle
  int m_t = -1;
  logic [15:0] m_word = '0;
  logic [15:0] pat = '0;
  logic [15:0] m_pat = '0;
  always @(posedge clk) begin
    if (!rst_n) m_t <= -1;
    else if (m_t < 0) begin
      if (start) begin m_t <= 0; m_word <= {ctrl, addr}; m_pat <= pat; end
    end else if (m_t == FR + G - 1) m_t <= -1;
    else m_t <= m_t + 1;
  end

  // slave model
  logic [15:0] sl_sh, sl_rx;
  int sl_n = 0;
  bit sl_armed = 0;
  always @(negedge ss_n) begin sl_sh = pat; miso = sl_sh[15]; sl_rx = '0; sl_n = 0; sl_armed = 1; end
  always @(negedge sclk) if (!ss_n) begin sl_sh = sl_sh << 1; miso = sl_sh[15]; end
  always @(posedge sclk) if (!ss_n) begin sl_rx = {sl_rx[14:0], mosi}; sl_n++; end
  always @(posedge ss_n) if (sl_armed) begin
    chk(sl_n == 16, "R5 rising edges per frame", sl_n, 16);
    chk(sl_rx == m_word, "R3 word on mosi", sl_rx, m_word);
    sl_armed = 0;
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n) begin
    logic e_ss, e_sclk, e_mosi, e_busy, e_done;
    int k;
    e_ss = 1; e_sclk = 0; e_mosi = 0; e_busy = 0; e_done = 0;
    if (m_t >= 0) begin
      e_busy = 1;
      if (m_t < FR) begin
        k = m_t / H;
        e_ss = 0; e_sclk = k[0];
        if (k < 32) e_mosi = m_word[15 - k/2];
      end
      e_done = (m_t == FR);
    end
    chk(ss_n == e_ss, "R5 ss_n", ss_n, e_ss);
    chk(sclk == e_sclk, "R5 sclk", sclk, e_sclk);
    chk(mosi == e_mosi, "R4 mosi", mosi, e_mosi);
    chk(busy == e_busy, "R2/R8 busy", busy, e_busy);
    chk(done == e_done, "R7 done", done, e_done);
    if (e_done) chk(status == m_pat, "R6 status", status, m_pat);
  end

  task automatic frame(input logic [9:0] a, input logic [5:0] c, input logic [15:0] p);
    @(negedge clk);
    addr = a; ctrl = c; pat = p; start = 1;
    @(negedge clk);
    start = 0;
    repeat (FR / 2) @(negedge clk);
    // R9: start mid-frame with different word must be ignored
    addr = ~a; ctrl = ~c; start = 1;
    @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  bit wd_hit = 0;
  initial begin
    #(8 * 150000);
    wd_hit = 1;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ss_n == 1 && sclk == 0 && mosi == 0 && busy == 0 && done == 0 && status == 0,
        "R1 reset state", {ss_n, sclk, mosi, busy, done}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    chk(ss_n == 1 && busy == 0 && status == 0, "R1 after reset", {ss_n, busy}, 2'b10);
    fork
      begin
        frame(10'h3FF, 6'h3F, 16'hFFFF);
        frame(10'h000, 6'h00, 16'h0000);
        frame(10'h2AA, 6'h15, 16'hA55A);
        frame(10'h155, 6'h2A, 16'h5AA5);
        frame(10'h001, 6'h20, 16'h8001);
        // R8/R9: start held continuously gives back-to-back frames at minimum gap
        @(negedge clk);
        addr = 10'h123; ctrl = 6'h0C; pat = 16'h1234; start = 1;
        repeat (3 * (FR + G + 1)) @(negedge clk);
        start = 0;
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
      end
      begin
        wait (wd_hit);
      end
    join_any
    if (wd_hit) chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule